// File: doc/BRIEF.md
# Rename-Aware Architectural Register File

This block holds the committed architectural state of a speculative out-of-order core. Each register carries three things: its committed value, a pending flag that says a younger in-flight instruction will overwrite it, and the reorder-entry tag of the newest such producer. The instruction being issued reads two source registers. For each one it receives either a usable value or the tag of the entry it must wait for. In the same cycle the issuing instruction claims its destination register with its own reorder-entry tag.

Results leave the reorder buffer in program order through the commit port. A commit always writes its value. It releases the pending flag only if the register still names that committing entry as its newest producer, so that a later rename of the same register stays in force. A mispredict flush drops every pending rename at once and keeps the committed values. The reorder buffer is outside this block. For each read port the block presents the pending producer tag as a lookup, and the buffer answers through a ready flag and a value. Tag value zero means "no producer", so rename tags are nonzero.

Top module: `rfr_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared to value zero and not pending, so a later read of any register returns value 0 and tag 0.
- R2: A read of a register that is not pending returns its stored value on `rd_val` and zero on `rd_tag`. The two read ports work independently of each other.
- R3: A read of a pending register whose producer is not ready (lookup ready low, no matching commit) returns the producer tag on `rd_tag` and zero on `rd_val`.
- R4: A read of a pending register whose lookup ready input is high returns the lookup value on `rd_val` and zero on `rd_tag`.
- R5: A rename (`ren_en` high, no flush) makes the register pending with `ren_tag` as its producer from the next cycle on.
- R6: A commit (`cmt_en` high) writes `cmt_val` into register `cmt_idx` at the clock edge, whether or not that register is pending.
- R7: A commit clears the pending flag only when `cmt_tag` equals the register's stored producer tag. Otherwise the flag and the tag are kept.
- R8: When a rename and a commit target the same register in the same cycle, the rename's tag and pending flag take effect and the commit's value is still written.
- R9: A flush clears the pending flag and tag of every register in the next cycle. A rename in the same cycle is dropped. Stored values and a same-cycle commit's value write are kept.
- R10: A read of a pending register that a same-cycle commit releases (same index, matching tag) returns `cmt_val` with tag 0. This has priority over the lookup input.
- R11: `rd_look_tag` shows the producer tag of the addressed register when it is pending, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | NUM_RD*IDX_W | Source register index per read port |
| rd_look_tag | output | NUM_RD*TAG_W | Producer tag sent to the reorder buffer lookup per port |
| rd_fwd_rdy | input | NUM_RD | Lookup answer: producer result is ready |
| rd_fwd_val | input | NUM_RD*DATA_W | Lookup answer: producer result value |
| rd_val | output | NUM_RD*DATA_W | Operand value (zero when a tag is returned) |
| rd_tag | output | NUM_RD*TAG_W | Tag to wait on, zero when the value is usable |
| ren_en | input | 1 | Rename the destination register this cycle |
| ren_idx | input | IDX_W | Destination register index |
| ren_tag | input | TAG_W | New reorder-entry tag, nonzero |
| cmt_en | input | 1 | Commit a result this cycle |
| cmt_idx | input | IDX_W | Committed destination register |
| cmt_tag | input | TAG_W | Tag of the committing entry |
| cmt_val | input | DATA_W | Committed value |
| flush | input | 1 | Mispredict flush of all pending renames |

## Verification
The bench builds the block with eight registers, a three-bit tag and 16-bit data, keeping the default two read ports. With only seven live tags and eight registers, random renames and commits often fall on the same register in the same cycle. Commits often arrive with a stale tag, and reads often land on a register that a same-cycle commit is releasing. This makes the rename-versus-commit ordering, the mismatched-tag release and the commit bypass common cases instead of rare ones. Flushes are frequent enough that many runs of renames are thrown away before their commits arrive.

// File: rtl/rfr_pkg.sv
// Package: rfr_pkg
// Shared types for the rename-aware register file.
// Assumes nothing beyond the users importing it.
package rfr_pkg;

    // Where a read port takes its operand from, in falling priority order.
    typedef enum logic [1:0] {
        SRC_FILE    = 2'd0,  // register not pending: committed value
        SRC_COMMIT  = 2'd1,  // pending, released by a same-cycle commit
        SRC_FWD     = 2'd2,  // pending, reorder buffer reports ready
        SRC_WAIT    = 2'd3   // pending, producer not ready: return tag
    } rd_src_e;

endpackage

// File: rtl/rfr_status_bank.sv
// Module: rfr_status_bank
// Holds the pending flag and newest producer tag of every register.
// A flush beats a rename, a rename beats a commit release, and a commit
// releases only on a tag match. Assumes rename tags are nonzero.
module rfr_status_bank #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 5,
    parameter int IDX_W    = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ren_en,
    input  logic [IDX_W-1:0]               ren_idx,
    input  logic [TAG_W-1:0]               ren_tag,
    input  logic                           cmt_en,
    input  logic [IDX_W-1:0]               cmt_idx,
    input  logic [TAG_W-1:0]               cmt_tag,
    input  logic                           flush,
    output logic [NUM_REGS-1:0]            busy_q,
    output logic [NUM_REGS-1:0][TAG_W-1:0] tag_q
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic             busy_r;
        logic [TAG_W-1:0] tag_r;
        logic             ren_hit;
        logic             rel_hit;

        // Decode whether this register is renamed or released this cycle.
        always_comb begin
            ren_hit = ren_en && (ren_idx == IDX_W'(i));
            rel_hit = cmt_en && (cmt_idx == IDX_W'(i)) && busy_r && (tag_r == cmt_tag);
        end

        // Update pending flag and producer tag by priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_r <= 1'b0;
                tag_r  <= '0;
            end else if (flush) begin
                busy_r <= 1'b0;
                tag_r  <= '0;
            end else if (ren_hit) begin
                busy_r <= 1'b1;
                tag_r  <= ren_tag;
            end else if (rel_hit) begin
                busy_r <= 1'b0;
                tag_r  <= '0;
            end
        end

        assign busy_q[i] = busy_r;
        assign tag_q[i]  = tag_r;
    end

endmodule

// File: rtl/rfr_value_bank.sv
// Module: rfr_value_bank
// Committed register values. Only the commit port writes, and it writes
// regardless of flush or rename status. Register zero is ordinary.
module rfr_value_bank #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmt_en,
    input  logic [IDX_W-1:0]                cmt_idx,
    input  logic [DATA_W-1:0]               cmt_val,
    output logic [NUM_REGS-1:0][DATA_W-1:0] val_q
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] val_r;

        // Write the committed value into this register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_r <= '0;
            end else if (cmt_en && (cmt_idx == IDX_W'(i))) begin
                val_r <= cmt_val;
            end
        end

        assign val_q[i] = val_r;
    end

endmodule

// File: rtl/rfr_read_port.sv
// Module: rfr_read_port
// One combinational source-operand read. Picks the committed value, a
// same-cycle commit bypass, a reorder buffer forward, or the producer tag.
// Assumes the lookup answer belongs to the tag shown on look_tag.
module rfr_read_port
    import rfr_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 5,
    parameter int IDX_W    = 5
) (
    input  logic [IDX_W-1:0]                rd_idx,
    input  logic [NUM_REGS-1:0]             busy_q,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] val_q,
    input  logic                            cmt_en,
    input  logic [IDX_W-1:0]                cmt_idx,
    input  logic [TAG_W-1:0]                cmt_tag,
    input  logic [DATA_W-1:0]               cmt_val,
    input  logic                            fwd_rdy,
    input  logic [DATA_W-1:0]               fwd_val,
    output logic [TAG_W-1:0]                look_tag,
    output logic [DATA_W-1:0]               op_val,
    output logic [TAG_W-1:0]                op_tag
);

    rd_src_e          src;
    logic             pend;
    logic [TAG_W-1:0] prod;

    // Classify the operand source for the addressed register.
    always_comb begin
        pend = busy_q[rd_idx];
        prod = tag_q[rd_idx];
        if (!pend)
            src = SRC_FILE;
        else if (cmt_en && (cmt_idx == rd_idx) && (cmt_tag == prod))
            src = SRC_COMMIT;
        else if (fwd_rdy)
            src = SRC_FWD;
        else
            src = SRC_WAIT;
    end

    // Drive the lookup tag and the operand from the chosen source.
    always_comb begin
        look_tag = pend ? prod : '0;
        op_val   = '0;
        op_tag   = '0;
        unique case (src)
            SRC_FILE:   op_val = val_q[rd_idx];
            SRC_COMMIT: op_val = cmt_val;
            SRC_FWD:    op_val = fwd_val;
            SRC_WAIT:   op_tag = prod;
        endcase
    end

endmodule

// File: rtl/rfr_regfile.sv
// Module: rfr_regfile
// Architectural register file with per-register rename status: NUM_RD
// source reads, one destination rename and one commit write per cycle,
// plus a flush of all pending renames. Tag zero means "no producer".
module rfr_regfile #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 5,
    parameter int NUM_RD   = 2,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][TAG_W-1:0]  rd_look_tag,
    input  logic [NUM_RD-1:0]             rd_fwd_rdy,
    input  logic [NUM_RD-1:0][DATA_W-1:0] rd_fwd_val,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_val,
    output logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag,
    input  logic                          ren_en,
    input  logic [IDX_W-1:0]              ren_idx,
    input  logic [TAG_W-1:0]              ren_tag,
    input  logic                          cmt_en,
    input  logic [IDX_W-1:0]              cmt_idx,
    input  logic [TAG_W-1:0]              cmt_tag,
    input  logic [DATA_W-1:0]             cmt_val,
    input  logic                          flush
);

    logic [NUM_REGS-1:0]             busy_q;
    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] val_q;

    rfr_status_bank #(
        .NUM_REGS (NUM_REGS),
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ren_en  (ren_en),
        .ren_idx (ren_idx),
        .ren_tag (ren_tag),
        .cmt_en  (cmt_en),
        .cmt_idx (cmt_idx),
        .cmt_tag (cmt_tag),
        .flush   (flush),
        .busy_q  (busy_q),
        .tag_q   (tag_q)
    );

    rfr_value_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_values (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmt_en  (cmt_en),
        .cmt_idx (cmt_idx),
        .cmt_val (cmt_val),
        .val_q   (val_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rfr_read_port #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .TAG_W    (TAG_W),
            .IDX_W    (IDX_W)
        ) u_port (
            .rd_idx   (rd_idx[p]),
            .busy_q   (busy_q),
            .tag_q    (tag_q),
            .val_q    (val_q),
            .cmt_en   (cmt_en),
            .cmt_idx  (cmt_idx),
            .cmt_tag  (cmt_tag),
            .cmt_val  (cmt_val),
            .fwd_rdy  (rd_fwd_rdy[p]),
            .fwd_val  (rd_fwd_val[p]),
            .look_tag (rd_look_tag[p]),
            .op_val   (rd_val[p]),
            .op_tag   (rd_tag[p])
        );
    end

endmodule

// File: rtl/rfr_regfile_chk.sv
// Module: rfr_regfile_chk
// Property checker bound into rfr_regfile. Watches the ports and the
// status bank outputs; drives nothing.
module rfr_regfile_chk #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 5,
    parameter int NUM_RD   = 2,
    parameter int IDX_W    = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    input logic [NUM_RD-1:0][DATA_W-1:0] rd_val,
    input logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag,
    input logic                          ren_en,
    input logic [IDX_W-1:0]              ren_idx,
    input logic [TAG_W-1:0]              ren_tag,
    input logic                          cmt_en,
    input logic [IDX_W-1:0]              cmt_idx,
    input logic [TAG_W-1:0]              cmt_tag,
    input logic [DATA_W-1:0]             cmt_val,
    input logic                          flush,
    input logic [NUM_REGS-1:0]           busy_q,
    input logic [NUM_REGS-1:0][TAG_W-1:0] tag_q
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (busy_q == '0));

    assert_rename_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ren_en |-> (ren_tag != '0));

    assert_rename_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_en && !flush) |=> (busy_q[$past(ren_idx)] && (tag_q[$past(ren_idx)] == $past(ren_tag))));

    assert_stale_commit_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_en && !flush && busy_q[cmt_idx] && (tag_q[cmt_idx] != cmt_tag)
         && !(ren_en && (ren_idx == cmt_idx)))
        |=> (busy_q[$past(cmt_idx)] && (tag_q[$past(cmt_idx)] == $past(tag_q[cmt_idx]))));

    assert_rename_beats_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_en && ren_en && !flush && (cmt_idx == ren_idx))
        |=> (busy_q[$past(ren_idx)] && (tag_q[$past(ren_idx)] == $past(ren_tag))));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_q == '0));

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        assert_tag_zeroes_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_tag[p] != '0) |-> (rd_val[p] == '0));

        assert_commit_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cmt_en && busy_q[rd_idx[p]] && (rd_idx[p] == cmt_idx) && (tag_q[rd_idx[p]] == cmt_tag))
            |-> ((rd_tag[p] == '0) && (rd_val[p] == cmt_val)));
    end

endmodule

bind rfr_regfile rfr_regfile_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W),
    .NUM_RD   (NUM_RD),
    .IDX_W    (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_val  (rd_val),
    .rd_tag  (rd_tag),
    .ren_en  (ren_en),
    .ren_idx (ren_idx),
    .ren_tag (ren_tag),
    .cmt_en  (cmt_en),
    .cmt_idx (cmt_idx),
    .cmt_tag (cmt_tag),
    .cmt_val (cmt_val),
    .flush   (flush),
    .busy_q  (busy_q),
    .tag_q   (tag_q)
);

// File: tb/sim_rfr_regfile.sv
// Bench: sim_rfr_regfile
// Directed corner cases followed by seeded random traffic, all checked
// against a behavioural model of the requirements.
module sim_rfr_regfile;

    localparam int NR  = 8;
    localparam int DW  = 16;
    localparam int TW  = 3;
    localparam int NRD = 2;
    localparam int IW  = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NRD-1:0][IW-1:0]  rd_idx = '0;
    logic [NRD-1:0][TW-1:0]  rd_look_tag;
    logic [NRD-1:0]          rd_fwd_rdy = '0;
    logic [NRD-1:0][DW-1:0]  rd_fwd_val = '0;
    logic [NRD-1:0][DW-1:0]  rd_val;
    logic [NRD-1:0][TW-1:0]  rd_tag;
    logic                    ren_en = 1'b0;
    logic [IW-1:0]           ren_idx = '0;
    logic [TW-1:0]           ren_tag = '0;
    logic                    cmt_en = 1'b0;
    logic [IW-1:0]           cmt_idx = '0;
    logic [TW-1:0]           cmt_tag = '0;
    logic [DW-1:0]           cmt_val = '0;
    logic                    flush = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    string force_req = "";

    logic [DW-1:0] m_val  [NR];
    logic          m_busy [NR];
    logic [TW-1:0] m_tag  [NR];

    always #10 clk = ~clk;

    rfr_regfile #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .NUM_RD(NRD)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_look_tag(rd_look_tag),
        .rd_fwd_rdy(rd_fwd_rdy), .rd_fwd_val(rd_fwd_val), .rd_val(rd_val),
        .rd_tag(rd_tag), .ren_en(ren_en), .ren_idx(ren_idx), .ren_tag(ren_tag),
        .cmt_en(cmt_en), .cmt_idx(cmt_idx), .cmt_tag(cmt_tag), .cmt_val(cmt_val),
        .flush(flush)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected operand for one port from the model and current inputs.
    task automatic expect_read(input int p, output logic [DW-1:0] ev,
                               output logic [TW-1:0] et, output string req);
        int i = int'(rd_idx[p]);
        if (!m_busy[i]) begin
            ev = m_val[i]; et = '0; req = "R2";
        end else if (cmt_en && cmt_idx == rd_idx[p] && cmt_tag == m_tag[i]) begin
            ev = cmt_val; et = '0; req = "R10";
        end else if (rd_fwd_rdy[p]) begin
            ev = rd_fwd_val[p]; et = '0; req = "R4";
        end else begin
            ev = '0; et = m_tag[i]; req = "R3";
        end
    endtask

    // Check both ports, then apply the clock edge to model and design.
    task automatic step();
        #2;
        for (int p = 0; p < NRD; p++) begin
            logic [DW-1:0] ev;
            logic [TW-1:0] et;
            string req;
            int i = int'(rd_idx[p]);
            expect_read(p, ev, et, req);
            if (force_req != "") req = force_req;
            check(rd_val[p] == ev, req, "value", int'(rd_val[p]), int'(ev));
            check(rd_tag[p] == et, req, "tag", int'(rd_tag[p]), int'(et));
            check(rd_look_tag[p] == (m_busy[i] ? m_tag[i] : '0), "R11", "lookup tag",
                  int'(rd_look_tag[p]), int'(m_busy[i] ? m_tag[i] : '0));
        end
        @(posedge clk);
        if (cmt_en) m_val[cmt_idx] = cmt_val;
        for (int r = 0; r < NR; r++) begin
            if (flush) begin
                m_busy[r] = 1'b0; m_tag[r] = '0;
            end else if (ren_en && ren_idx == IW'(r)) begin
                m_busy[r] = 1'b1; m_tag[r] = ren_tag;
            end else if (cmt_en && cmt_idx == IW'(r) && m_busy[r] && m_tag[r] == cmt_tag) begin
                m_busy[r] = 1'b0; m_tag[r] = '0;
            end
        end
        @(negedge clk);
        ren_en = 1'b0; cmt_en = 1'b0; flush = 1'b0; rd_fwd_rdy = '0;
        force_req = "";
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int r = 0; r < NR; r++) begin
            m_val[r] = '0; m_busy[r] = 1'b0; m_tag[r] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset.
        for (int r = 0; r < NR; r += 2) begin
            rd_idx[0] = IW'(r); rd_idx[1] = IW'(r + 1);
            force_req = "R1"; step();
        end

        // R5: rename r3 to tag 5, then read it back on both ports.
        ren_en = 1; ren_idx = 3; ren_tag = 5; step();
        rd_idx[0] = 3; rd_idx[1] = 3; force_req = "R5"; step();

        // R8: commit tag 5 and rename tag 6 on r3 in one cycle.
        cmt_en = 1; cmt_idx = 3; cmt_tag = 5; cmt_val = 16'h1234;
        ren_en = 1; ren_idx = 3; ren_tag = 6; step();
        force_req = "R8"; step();
        // Forwarding on port 1 shows the pending value comes from the lookup.
        rd_fwd_rdy[1] = 1; rd_fwd_val[1] = 16'hbeef; step();

        // R6: commit tag 6 releases r3 and writes its value.
        cmt_en = 1; cmt_idx = 3; cmt_tag = 6; cmt_val = 16'h0055; step();
        force_req = "R6"; step();

        // R7: two renames of r2, then a commit of the older one.
        ren_en = 1; ren_idx = 2; ren_tag = 1; step();
        ren_en = 1; ren_idx = 2; ren_tag = 2; step();
        cmt_en = 1; cmt_idx = 2; cmt_tag = 1; cmt_val = 16'h0007; step();
        rd_idx[0] = 2; rd_idx[1] = 2; force_req = "R7"; step();

        // R9: flush with a same-cycle rename and commit.
        ren_en = 1; ren_idx = 4; ren_tag = 3; step();
        flush = 1; ren_en = 1; ren_idx = 5; ren_tag = 4;
        cmt_en = 1; cmt_idx = 6; cmt_tag = 7; cmt_val = 16'h0009; step();
        rd_idx[0] = 4; rd_idx[1] = 5; force_req = "R9"; step();
        rd_idx[0] = 6; rd_idx[1] = 2; force_req = "R9"; step();

        // R10: bypass of a releasing commit beats a ready lookup.
        ren_en = 1; ren_idx = 1; ren_tag = 2; step();
        rd_idx[0] = 1; rd_idx[1] = 1;
        rd_fwd_rdy = '1; rd_fwd_val[0] = 16'haaaa; rd_fwd_val[1] = 16'hbbbb;
        cmt_en = 1; cmt_idx = 1; cmt_tag = 2; cmt_val = 16'h4321;
        force_req = "R10"; step();

        // Random traffic.
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < NRD; p++) begin
                rd_idx[p]     = IW'($urandom_range(NR - 1));
                rd_fwd_rdy[p] = ($urandom_range(3) == 0);
                rd_fwd_val[p] = DW'($urandom);
            end
            ren_en  = ($urandom_range(1) == 1);
            ren_idx = IW'($urandom_range(NR - 1));
            ren_tag = TW'($urandom_range((1 << TW) - 1, 1));
            cmt_en  = ($urandom_range(1) == 1);
            cmt_idx = IW'($urandom_range(NR - 1));
            cmt_tag = ($urandom_range(4) < 3) ? m_tag[cmt_idx] : TW'($urandom);
            cmt_val = DW'($urandom);
            flush   = ($urandom_range(19) == 0);
            step();
        end

        finish_run();
    end

endmodule